// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block connects a synchronous request port to an asynchronous byte-wide static RAM of 512K locations. The host presents a request with a valid flag, a write flag, a 19-bit address and write data. The controller drops its ready output for the whole transaction. It runs the memory's chip-enable, output-enable and write-enable pins through a timed sequence. It then pulses a done strobe. A read returns the captured byte alongside that strobe.

Every memory timing limit is a parameter in nanoseconds. Each one is turned into a whole number of clock cycles by ceiling division with the clock period, and no count is ever less than one cycle. Between transactions the chip is deselected, so it falls into its own low-power state. After a read, the controller waits for the memory to release the data bus before it drives write data. A retention request holds the chip deselected through a supply-low phase. The chip stays deselected for a setup time before the phase and for a recovery time after it.

The data bus reaches the pad ring as three signals: a driven value, an output enable and a sampled input. The pad merges them into the bidirectional pins.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and right after reset, the chip is deselected (sramCeN=1, sramCe2=0), sramOeN=1 and sramWeN=1. The controller does not drive the bus (sramDqOe=0), reqReady=1, rspDone=0 and retReady=0.
- R2: For the whole of a read, the pins are sramCeN=0, sramCe2=1, sramOeN=0 and sramWeN=1, with sramAddr equal to the request address and sramDqOe=0.
- R3: A read samples the bus only after the enables and the address have been stable for at least ceil(T_ACCESS_NS/CLK_PERIOD_NS) cycles. rspDone rises exactly that count plus 2 cycles after the accepting clock edge, and rspRdata carries the stored byte. rspRdata holds its value until the next read completes.
- R4: During a write, sramOeN stays 1 and the chip stays selected at the request address. sramWeN goes low for max(ceil(T_WE_PULSE_NS/T), ceil(T_DATA_SETUP_NS/T)) cycles after ceil(T_ADDR_SETUP_NS/T) setup cycles. With no pending bus release, rspDone comes setup+pulse+2 cycles after acceptance.
- R5: sramDqOe is high in exactly the cycles where sramWeN is low, plus one hold cycle after it. sramDqOut stays constant over that window.
- R6: After a read deasserts output enable and chip enable, the controller drives the bus no earlier than max(ceil(T_OE_RELEASE_NS/T), ceil(T_CE_RELEASE_NS/T)) cycles later.
- R7: When no transaction is in progress, the chip is deselected and both sramOeN and sramWeN are 1.
- R8: reqReady is low from the accepting edge until the cycle in which rspDone is high. rspDone is a single-cycle pulse.
- R9: With retReq high while idle, reqReady falls in the same cycle and the chip stays deselected. retReady rises ceil(T_RET_SETUP_NS/T)+1 cycles after the edge that first sees retReq.
- R10: After retReq falls, retReady drops on the next cycle. reqReady returns ceil(T_RET_RECOVER_NS/T)+1 cycles after the edge that sees retReq low. A request held valid during retention is not performed: no done pulse and no write to memory.
- R11: A timing parameter of 0 ns still gives one cycle. With the default address setup of 0 ns, the write setup lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (19) | Byte address |
| reqWdata | input | DATA_W (8) | Write byte |
| rspDone | output | 1 | One-cycle completion strobe |
| rspRdata | output | DATA_W (8) | Last byte read |
| retReq | input | 1 | Data-retention request |
| retReady | output | 1 | Chip has been deselected for the setup time; supply may be lowered |
| sramCeN | output | 1 | Chip enable, active low |
| sramCe2 | output | 1 | Second chip enable, active high |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write enable, active low |
| sramAddr | output | ADDR_W (19) | Memory address |
| sramDqOut | output | DATA_W (8) | Data driven toward the pad |
| sramDqOe | output | 1 | Pad output enable for the data bus |
| sramDqIn | input | DATA_W (8) | Data sampled from the pad |

## Verification
The hardest case is a write issued the very next cycle after a read completes. At that point the memory may still be driving the bus during its release time. The bench reaches it by starting the write on the cycle after the read's done strobe. Its memory model keeps driving for the release window after the enables drop and counts every cycle in which both sides drive. Its read path returns a wrong byte unless the enables have been stable for the full access time, so a short access window shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_CAPTURE,
    ST_TURNAROUND,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RETENTION
  } ctrlState_e;

  typedef enum logic [1:0] {
    RET_SETUP,
    RET_HOLD,
    RET_RECOVER
  } retPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic chipSel;
    logic outEn;
    logic wrEn;
    logic drvData;
    logic latchReq;
    logic capture;
  } ctlStrobe_t;

  // ceiling conversion of a nanosecond limit to clock cycles, at least one
  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned periodNs);
    int unsigned c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 4,
  parameter int unsigned T_ACCESS_NS     = 70,
  parameter int unsigned T_OE_RELEASE_NS = 25,
  parameter int unsigned T_CE_RELEASE_NS = 25,
  parameter int unsigned T_ADDR_SETUP_NS = 0,
  parameter int unsigned T_WE_PULSE_NS   = 45,
  parameter int unsigned T_DATA_SETUP_NS = 30,
  parameter int unsigned T_RET_SETUP_NS  = 20,
  parameter int unsigned T_RET_RECOVER_NS = 70
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       retReq,
  output logic       reqReady,
  output logic       rspDone,
  output logic       retReady,
  output ctlStrobe_t ctl
);

  localparam int unsigned ACC_CYC   = nsToCycles(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned OEREL_CYC = nsToCycles(T_OE_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned CEREL_CYC = nsToCycles(T_CE_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned REL_CYC   = (OEREL_CYC > CEREL_CYC) ? OEREL_CYC : CEREL_CYC;
  localparam int unsigned SETUP_CYC = nsToCycles(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned WEP_CYC   = nsToCycles(T_WE_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_CYC    = nsToCycles(T_DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = (WEP_CYC > DS_CYC) ? WEP_CYC : DS_CYC;
  localparam int unsigned RSET_CYC  = nsToCycles(T_RET_SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned RREC_CYC  = nsToCycles(T_RET_RECOVER_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_A     = (ACC_CYC > REL_CYC) ? ACC_CYC : REL_CYC;
  localparam int unsigned MAX_B     = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_C     = (RSET_CYC > RREC_CYC) ? RSET_CYC : RREC_CYC;
  localparam int unsigned MAX_AB    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_CYC   = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  ctrlState_e         state;
  retPhase_e          retPhase;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   relCnt;
  logic               doneQ;
  logic               retReadyQ;
  logic               accept;

  assign reqReady = (state == ST_IDLE) && !retReq;
  assign accept   = reqReady && reqValid;
  assign rspDone  = doneQ;
  assign retReady = retReadyQ;

  always_comb begin
    ctl          = '0;
    ctl.latchReq = accept;
    ctl.chipSel  = (state == ST_RD_ACCESS) || (state == ST_RD_CAPTURE) ||
                   (state == ST_WR_SETUP)  || (state == ST_WR_PULSE)   ||
                   (state == ST_WR_HOLD);
    ctl.outEn    = (state == ST_RD_ACCESS) || (state == ST_RD_CAPTURE);
    ctl.wrEn     = (state == ST_WR_PULSE);
    ctl.drvData  = (state == ST_WR_PULSE) || (state == ST_WR_HOLD);
    ctl.capture  = (state == ST_RD_CAPTURE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      retPhase  <= RET_SETUP;
      cnt       <= '0;
      relCnt    <= '0;
      doneQ     <= 1'b0;
      retReadyQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (relCnt != '0) relCnt <= relCnt - 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (retReq) begin
            state    <= ST_RETENTION;
            retPhase <= RET_SETUP;
            cnt      <= CNT_W'(RSET_CYC - 1);
          end else if (reqValid) begin
            if (!reqWrite) begin
              state <= ST_RD_ACCESS;
              cnt   <= CNT_W'(ACC_CYC - 1);
            end else if (relCnt != '0) begin
              state <= ST_TURNAROUND;
            end else begin
              state <= ST_WR_SETUP;
              cnt   <= CNT_W'(SETUP_CYC - 1);
            end
          end
        end
        ST_RD_ACCESS: begin
          if (cnt == '0) state <= ST_RD_CAPTURE;
          else cnt <= cnt - 1'b1;
        end
        ST_RD_CAPTURE: begin
          state  <= ST_IDLE;
          doneQ  <= 1'b1;
          relCnt <= CNT_W'(REL_CYC);
        end
        ST_TURNAROUND: begin
          if (relCnt == '0) begin
            state <= ST_WR_SETUP;
            cnt   <= CNT_W'(SETUP_CYC - 1);
          end
        end
        ST_WR_SETUP: begin
          if (cnt == '0) begin
            state <= ST_WR_PULSE;
            cnt   <= CNT_W'(PULSE_CYC - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WR_PULSE: begin
          if (cnt == '0) state <= ST_WR_HOLD;
          else cnt <= cnt - 1'b1;
        end
        ST_WR_HOLD: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        ST_RETENTION: begin
          unique case (retPhase)
            RET_SETUP: begin
              if (!retReq) begin
                retPhase <= RET_RECOVER;
                cnt      <= CNT_W'(RREC_CYC - 1);
              end else if (cnt == '0) begin
                retPhase  <= RET_HOLD;
                retReadyQ <= 1'b1;
              end else cnt <= cnt - 1'b1;
            end
            RET_HOLD: begin
              if (!retReq) begin
                retPhase  <= RET_RECOVER;
                retReadyQ <= 1'b0;
                cnt       <= CNT_W'(RREC_CYC - 1);
              end
            end
            default: begin
              if (retReq) begin
                retPhase <= RET_SETUP;
                cnt      <= CNT_W'(RSET_CYC - 1);
              end else if (cnt == '0) state <= ST_IDLE;
              else cnt <= cnt - 1'b1;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: write data never driven while the bus-release window is still open
  p_turn_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_PULSE) |-> (relCnt == '0));

  // R8: done is a single-cycle strobe
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R9: retention-ready only while the retention sequence owns the chip
  p_ret_owned_r9: assert property (@(posedge clk) disable iff (!rstN)
    retReadyQ |-> (state == ST_RETENTION));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sramCeN,
  output logic              sramCe2,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) rdataQ <= sramDqIn;
    end
  end

  assign sramCeN   = !ctl.chipSel;
  assign sramCe2   = ctl.chipSel;
  assign sramOeN   = !ctl.outEn;
  assign sramWeN   = !ctl.wrEn;
  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = ctl.drvData;
  assign rspRdata  = rdataQ;

  // R5: driven write byte does not change inside the drive window
  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.drvData && $past(ctl.drvData)) |-> $stable(sramDqOut));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int          ADDR_W           = 19,
  parameter int          DATA_W           = 8,
  parameter int unsigned CLK_PERIOD_NS    = 4,
  parameter int unsigned T_ACCESS_NS      = 70,
  parameter int unsigned T_OE_RELEASE_NS  = 25,
  parameter int unsigned T_CE_RELEASE_NS  = 25,
  parameter int unsigned T_ADDR_SETUP_NS  = 0,
  parameter int unsigned T_WE_PULSE_NS    = 45,
  parameter int unsigned T_DATA_SETUP_NS  = 30,
  parameter int unsigned T_RET_SETUP_NS   = 20,
  parameter int unsigned T_RET_RECOVER_NS = 70
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  input  logic              retReq,
  output logic              retReady,
  output logic              sramCeN,
  output logic              sramCe2,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  ctlStrobe_t ctl;

  sram_ctrl_fsm #(
    .CLK_PERIOD_NS   (CLK_PERIOD_NS),
    .T_ACCESS_NS     (T_ACCESS_NS),
    .T_OE_RELEASE_NS (T_OE_RELEASE_NS),
    .T_CE_RELEASE_NS (T_CE_RELEASE_NS),
    .T_ADDR_SETUP_NS (T_ADDR_SETUP_NS),
    .T_WE_PULSE_NS   (T_WE_PULSE_NS),
    .T_DATA_SETUP_NS (T_DATA_SETUP_NS),
    .T_RET_SETUP_NS  (T_RET_SETUP_NS),
    .T_RET_RECOVER_NS(T_RET_RECOVER_NS)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .retReq   (retReq),
    .reqReady (reqReady),
    .rspDone  (rspDone),
    .retReady (retReady),
    .ctl      (ctl)
  );

  sram_ctrl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .sramDqIn  (sramDqIn),
    .rspRdata  (rspRdata),
    .sramCeN   (sramCeN),
    .sramCe2   (sramCe2),
    .sramOeN   (sramOeN),
    .sramWeN   (sramWeN),
    .sramAddr  (sramAddr),
    .sramDqOut (sramDqOut),
    .sramDqOe  (sramDqOe)
  );

  // R4: output enable and write enable never active together
  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramOeN);

  // R2: address does not move while the chip stays selected
  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr));

  // R5: bus is driven whenever write enable is low
  p_we_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> sramDqOe);

  // R8: an accepted request makes the port busy on the next cycle
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqReady && !rspDone));

endmodule

// File: tb/async_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module async_sram_ctrl_tb_top;

  localparam int PER_NS = 4;
  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER_NS - 1) / PER_NS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int ACC  = cyc(70);
  localparam int RELB = (cyc(25) > cyc(25)) ? cyc(25) : cyc(25);
  localparam int SETB = cyc(0);
  localparam int PULB = (cyc(45) > cyc(30)) ? cyc(45) : cyc(30);
  localparam int DSB  = cyc(30);
  localparam int RSB  = cyc(20);
  localparam int RRB  = cyc(70);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        retReq = 1'b0;
  logic        reqReady, rspDone, retReady;
  logic [7:0]  rspRdata;
  logic        sramCeN, sramCe2, sramOeN, sramWeN, sramDqOe;
  logic [18:0] sramAddr;
  logic [7:0]  sramDqOut;
  logic [7:0]  sramDqIn;

  always #2 clk = ~clk;

  async_sram_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata), .retReq(retReq), .retReady(retReady),
    .sramCeN(sramCeN), .sramCe2(sramCe2), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramAddr(sramAddr), .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0] memArr [int];
  logic [7:0] expMem [int];
  logic       memDrv = 1'b0;
  logic [7:0] memOut = 8'h00;
  int  accCnt = 0, relLeft = 0, weLowCnt = 0, stableCnt = 0;
  logic [18:0] prevAddr = '0;
  logic        prevRd = 1'b0, prevWeLow = 1'b0;
  logic [7:0]  weData = '0;
  int contention = 0, shortPulse = 0, driveViol = 0, oeInWrite = 0, commits = 0;

  function automatic logic [7:0] memRead(input logic [18:0] a);
    if (memArr.exists(int'(a))) return memArr[int'(a)];
    return a[7:0] ^ 8'hC3;
  endfunction

  assign sramDqIn = memDrv ? memOut : 8'hFF;

  always @(negedge clk) begin
    bit sel, rd, drv;
    sel = rstN && !sramCeN && sramCe2;
    rd  = sel && !sramOeN && sramWeN;
    if (rd && prevRd && sramAddr == prevAddr) accCnt++;
    else if (rd) accCnt = 1;
    else accCnt = 0;
    drv = rd || (relLeft > 0);
    if (rd) relLeft = RELB;
    else if (relLeft > 0) relLeft--;
    if (drv && sramDqOe) contention++;
    memDrv <= drv;
    memOut <= (rd && accCnt >= ACC + 1) ? memRead(sramAddr) : 8'h5A;
    // write side
    if (sramDqOe && sramWeN && !prevWeLow) driveViol++;
    if (!sramWeN && !sramOeN) oeInWrite++;
    if (sel && !sramWeN) begin
      if (!sramDqOe) driveViol++;
      if (weLowCnt == 0) begin weData = sramDqOut; stableCnt = 1; end
      else if (sramDqOut == weData) stableCnt++;
      else begin weData = sramDqOut; stableCnt = 1; end
      weLowCnt++;
    end else if (weLowCnt > 0) begin
      if (weLowCnt < PULB || stableCnt < DSB) shortPulse++;
      if (!sramDqOe || sramDqOut != weData) driveViol++;
      memArr[int'(sramAddr)] = weData;
      commits++;
      weLowCnt = 0;
    end
    prevWeLow = rstN && !sramWeN;
    prevRd = rd;
    prevAddr = sramAddr;
  end

  // ---------------- watchdog ----------------
  int wdCyc = 0;
  always @(posedge clk) begin
    wdCyc++;
    if (wdCyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", wdCyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- request driver ----------------
  task automatic runReq(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        output int lat, output int pinErr, output int idleErr);
    pinErr = 0; idleErr = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) reqValid = 1'b0;
      if (!rspDone) begin
        if (reqReady) pinErr++;
        if (!wr && (sramCeN || !sramCe2 || sramOeN || !sramWeN || sramAddr != a || sramDqOe)) pinErr++;
        if (wr && (!sramOeN || (!sramCeN && (!sramCe2 || sramAddr != a)))) pinErr++;
      end else begin
        if (!reqReady) pinErr++;
        if (!sramCeN || sramCe2 || !sramOeN || !sramWeN || sramDqOe) idleErr++;
      end
    end while (!rspDone && lat < 300);
    if (wr) expMem[int'(a)] = d;
  endtask

  task automatic doWrite(input logic [18:0] a, input logic [7:0] d, input bit exact);
    int lat, pe, ie;
    runReq(1'b1, a, d, lat, pe, ie);
    if (exact) check(lat == SETB + PULB + 2, "R4", "write latency (R11 one-cycle setup)", lat, SETB + PULB + 2);
    else check(lat >= SETB + PULB + 2, "R6", "write after read latency", lat, SETB + PULB + 2);
    check(pe == 0, "R8", "write pin/ready errors", pe, 0);
    check(ie == 0, "R7", "deselect after write", ie, 0);
  endtask

  task automatic doRead(input logic [18:0] a);
    int lat, pe, ie;
    runReq(1'b0, a, 8'h00, lat, pe, ie);
    check(lat == ACC + 2, "R3", "read latency", lat, ACC + 2);
    check(rspRdata == expMem[int'(a)], "R3", "read data", rspRdata, expMem[int'(a)]);
    check(pe == 0, "R2", "read pin pattern", pe, 0);
    check(ie == 0, "R7", "deselect after read", ie, 0);
  endtask

  initial begin
    int lat, ign;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(sramCeN && !sramCe2 && sramOeN && sramWeN && !sramDqOe && !rspDone && !retReady,
          "R1", "pins during reset", {sramCeN, sramCe2, sramOeN, sramWeN, sramDqOe}, 5'b10110);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && !rspDone && !retReady && sramCeN && !sramCe2 && sramOeN && sramWeN && !sramDqOe,
          "R1", "state after reset", {reqReady, rspDone, retReady}, 3'b100);

    // back-to-back writes, distinct address patterns
    doWrite(19'h00000, 8'h11, 1'b1);
    doWrite(19'h7FFFF, 8'hA7, 1'b1);
    doWrite(19'h12345, 8'h3C, 1'b1);
    doWrite(19'h55555, 8'hF0, 1'b1);
    doWrite(19'h12345, 8'h96, 1'b1);   // overwrite, last value wins

    doRead(19'h00000);
    doRead(19'h7FFFF);
    doRead(19'h12345);
    held = rspRdata;
    // write directly behind a read: bus release window (R6)
    doWrite(19'h2AAAA, 8'h5C, 1'b0);
    check(rspRdata == held, "R3", "read data held across write", rspRdata, held);
    doRead(19'h2AAAA);
    doWrite(19'h55555, 8'h0F, 1'b0);
    doRead(19'h55555);

    // retention entry
    @(negedge clk);
    retReq = 1'b1;
    #1;
    check(!reqReady, "R9", "ready drops with retention request", reqReady, 0);
    @(posedge clk);
    lat = 0; ign = 0;
    do begin
      @(negedge clk); lat++;
      if (!sramCeN || sramCe2) ign++;
    end while (!retReady && lat < 100);
    check(lat == RSB + 1, "R9", "retention-ready delay", lat, RSB + 1);
    check(ign == 0, "R9", "chip deselected in setup", ign, 0);
    // request during retention must be ignored
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 19'h00000; reqWdata = 8'hEE;
    ign = 0;
    repeat (10) begin
      @(negedge clk);
      if (rspDone || !sramWeN || !sramCeN || sramCe2 || reqReady) ign++;
    end
    reqValid = 1'b0;
    check(ign == 0, "R10", "request ignored in retention", ign, 0);
    retReq = 1'b0;
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk); lat++;
      if (lat == 1) check(!retReady, "R10", "retention-ready falls", retReady, 0);
    end while (!reqReady && lat < 100);
    check(lat == RRB + 1, "R10", "recovery delay", lat, RRB + 1);
    doRead(19'h00000);   // still old value (R10)

    repeat (4) @(negedge clk);
    check(contention == 0, "R6", "bus contention cycles", contention, 0);
    check(driveViol == 0, "R5", "drive window violations", driveViol, 0);
    check(shortPulse == 0, "R4", "short write pulse or setup", shortPulse, 0);
    check(oeInWrite == 0, "R4", "output enable during write", oeInWrite, 0);
    check(commits == 7, "R4", "writes committed to memory", commits, 7);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule